// File: doc/BRIEF.md
# I2C Bit-Period Watchdog

This block sits beside an I2C master controller and watches the sampled SCL line. It measures how long the current bit period has lasted, counting system clock cycles since the last SCL transition. If any single bit period runs past a programmable limit, the block raises a timeout. The limit applies to every data bit and to every acknowledge bit alike. The timeout sets a sticky status flag and emits a one-cycle reset request, so that a controller state machine stuck mid-transfer is forced back to a known state.

A slave that stretches the clock by holding SCL low also keeps the bit period open. That time counts against the limit in the same way as any other wait. The limit must therefore cover the longest stretch that any device on the bus may apply. A limit that is too short aborts transfers partway through. The watchdog knows nothing of transaction length, and any timeout kept on the whole transfer runs separately from this one.

Top module: `i2c_bit_watchdog`

## Requirements
- R1: After reset, `tmo_flag_o` and `ctl_rst_o` are 0.
- R2: Counting starts while `en_i` is 1 and `xfer_act_i` is 1. If SCL stays steady, `ctl_rst_o` goes high exactly `limit_i` clock cycles after the first cycle in which both enables are sampled high.
- R3: A rising or a falling SCL transition restarts the count from zero. The transition takes effect three clocks after it appears on `scl_i`: two synchroniser flops and one edge register. So SCL toggling at intervals shorter than the limit never causes a timeout.
- R4: `ctl_rst_o` is a single-cycle pulse. The count saturates at the limit, so a bit period that stays stuck produces only one pulse.
- R5: `tmo_flag_o` sets in the same cycle as the pulse and stays set until `tmo_clr_i` is sampled high. If a new expiry and a clear arrive in the same cycle, the flag stays set.
- R6: A `limit_i` of 0 disables detection, so no pulse is produced however long SCL stays still.
- R7: While `en_i` is 0 the count is held at zero. After re-enabling, the full limit is timed from the re-enable cycle.
- R8: While `xfer_act_i` is 0 the count is held at zero and no timeout occurs.
- R9: SCL held low, as in a clock stretch during an acknowledge bit, is timed the same way as SCL held high.
- R10: After an expiry, a new SCL transition re-arms the watchdog, and a later stuck period produces another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Watchdog enable |
| xfer_act_i | input | 1 | High while the controller is running a transfer |
| limit_i | input | 20 | Per-bit limit in clock cycles; 0 disables |
| scl_i | input | 1 | Sampled SCL line (asynchronous to clk) |
| tmo_clr_i | input | 1 | One-cycle clear of the sticky flag |
| tmo_flag_o | output | 1 | Sticky timeout status |
| ctl_rst_o | output | 1 | One-cycle reset request to the controller |

## Verification
The bench times expiry to the exact cycle, both from an enable edge and from an SCL edge. An off-by-one in the compare or in the synchroniser depth would move the pulse, and the scoreboard would see it a cycle early or late. Long stuck intervals check that the count saturates. A wrapping counter would emit a second pulse, and a level-style output would hold the reset high. SCL is toggled just inside the limit, with both polarities held stuck. A design that restarted on only one edge direction, or timed only the high phase, would fire when it should not or stay silent during a stretched low.

// File: rtl/i2c_wdog_pkg.sv
package i2c_wdog_pkg;
  localparam int unsigned WD_LIMIT_W = 20;
  localparam int unsigned WD_SYNC_N  = 2;

  typedef enum logic [1:0] {
    WD_HOLD    = 2'd0,
    WD_COUNT   = 2'd1,
    WD_EXPIRED = 2'd2
  } wd_state_e;
endpackage

// File: rtl/scl_edge_sense.sv
module scl_edge_sense #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  output logic edge_o
);
  logic [SYNC_N-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= scl_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[SYNC_N-1];
  end

  assign edge_o = chain_q[SYNC_N-1] ^ prev_q;
endmodule

// File: rtl/bit_period_counter.sv
module bit_period_counter
  import i2c_wdog_pkg::*;
#(
  parameter int unsigned LIMIT_W = WD_LIMIT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               act_i,
  input  logic               restart_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               fire_o,
  output wd_state_e          state_o
);
  logic [LIMIT_W-1:0] cnt_q;
  logic               run;
  logic               below;

  assign run     = en_i && act_i && !restart_i && (limit_i != '0);
  assign below   = cnt_q < limit_i;
  assign fire_o  = run && below && ((cnt_q + 1'b1) == limit_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i || !act_i || restart_i) cnt_q <= '0;
    else if (run && below)                  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (!run)       state_o = WD_HOLD;
    else if (below) state_o = WD_COUNT;
    else            state_o = WD_EXPIRED;
  end

  // R7 / R8: no count survives a disabled or idle cycle
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!en_i || !act_i) |=> (cnt_q == '0));
  // R4: saturated counter never advances
  p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == WD_EXPIRED && $stable(limit_i) && run) |=> $stable(cnt_q));
endmodule

// File: rtl/timeout_status.sv
module timeout_status (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire_i;
      if (fire_i)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // R4: reset request lasts one cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R5: flag accompanies the pulse
  p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> flag_o);
  // R5: flag is sticky until cleared
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/i2c_bit_watchdog.sv
module i2c_bit_watchdog
  import i2c_wdog_pkg::*;
#(
  parameter int unsigned LIMIT_W = WD_LIMIT_W,
  parameter int unsigned SYNC_N  = WD_SYNC_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               xfer_act_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               scl_i,
  input  logic               tmo_clr_i,
  output logic               tmo_flag_o,
  output logic               ctl_rst_o
);
  logic      scl_edge;
  logic      fire;
  wd_state_e wd_state;

  scl_edge_sense #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .scl_i(scl_i), .edge_o(scl_edge)
  );

  bit_period_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en_i), .act_i(xfer_act_i),
    .restart_i(scl_edge), .limit_i(limit_i),
    .fire_o(fire), .state_o(wd_state)
  );

  timeout_status u_stat (
    .clk(clk), .rst(rst), .fire_i(fire), .clr_i(tmo_clr_i),
    .flag_o(tmo_flag_o), .pulse_o(ctl_rst_o)
  );

  // R6: zero limit never produces a reset request
  p_zero_limit_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(limit_i) == '0) |-> !ctl_rst_o);
  // R8: idle controller never gets a reset request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(xfer_act_i) || !$past(en_i)) |-> !ctl_rst_o);
  // R4: an expiry is only reported from the counting state
  p_fire_state_r4: assert property (@(posedge clk) disable iff (rst)
    fire |-> (wd_state == WD_COUNT));
endmodule

// File: tb/tb_i2c_bit_watchdog.sv
module tb_i2c_bit_watchdog;
  localparam int LW = 20;
  localparam int EDGE_LAT = 3;

  logic clk = 1'b0;
  logic rst, en, act, scl, clr;
  logic [LW-1:0] lim;
  logic flag, pls;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_bit_watchdog dut (
    .clk(clk), .rst(rst), .en_i(en), .xfer_act_i(act), .limit_i(lim),
    .scl_i(scl), .tmo_clr_i(clr), .tmo_flag_o(flag), .ctl_rst_o(pls)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares each pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst && pls) begin
      if (exp_q.size() == 0) chk(1'b0, "R4/R6/R8 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2/R3 pulse cycle", cyc, e);
      end
    end
  end

  task automatic drain(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    rst = 1; en = 0; act = 0; scl = 1; clr = 0; lim = 20'd0;
    tick(4);
    rst = 0;
    tick(1);
    // R1
    chk(flag == 1'b0, "R1 flag", flag, 0);
    chk(pls == 1'b0, "R1 pulse", pls, 0);

    // R2: exact expiry from activation, SCL high
    lim = 20'd10; en = 1;
    tick(5);
    act = 1; exp_q.push_back(cyc + 10);
    tick(9);
    chk(pls == 1'b0, "R2 no early pulse", pls, 0);
    tick(1);
    chk(pls == 1'b1, "R2 pulse at limit", pls, 1);
    chk(flag == 1'b1, "R5 flag set", flag, 1);
    // R4: saturated, stays quiet
    tick(40);
    drain("R4 single pulse per stuck interval");
    chk(flag == 1'b1, "R5 flag sticky", flag, 1);
    clr = 1; tick(1); clr = 0;
    chk(flag == 1'b0, "R5 flag cleared", flag, 0);

    // R3: toggling inside the limit never expires
    act = 0; tick(2); act = 1;
    for (int i = 0; i < 12; i++) begin scl = ~scl; tick(8); end
    drain("R3 toggling within limit");
    chk(flag == 1'b0, "R3 no flag", flag, 0);

    // R9 + R10: SCL now held at final level; stop at low, timed from edge
    act = 0; scl = 1; tick(6); act = 1; tick(2);
    scl = 0; exp_q.push_back(cyc + EDGE_LAT + 10);
    tick(EDGE_LAT + 9);
    chk(pls == 1'b0, "R9 low hold not yet", pls, 0);
    tick(1);
    chk(pls == 1'b1, "R9 low hold expires", pls, 1);
    tick(20);
    // R10: rearm by edge
    scl = 1; exp_q.push_back(cyc + EDGE_LAT + 10);
    tick(EDGE_LAT + 15);
    drain("R10 rearmed second pulse");

    // R5: clear coincident with a new expiry keeps flag
    act = 0; tick(2); clr = 1; tick(1); clr = 0;
    chk(flag == 1'b0, "R5 cleared again", flag, 0);
    act = 1; exp_q.push_back(cyc + 10);
    tick(9); clr = 1; tick(1); clr = 0;
    chk(flag == 1'b1, "R5 set wins over clear", flag, 1);
    tick(3);
    drain("R5 coincident pulse");
    clr = 1; tick(1); clr = 0;

    // R6: zero limit
    act = 0; lim = 20'd0; tick(2); act = 1;
    tick(60);
    drain("R6 zero limit silent");
    chk(flag == 1'b0, "R6 flag", flag, 0);

    // R7: disable mid-count restarts timing
    act = 0; lim = 20'd12; tick(2); act = 1;
    tick(8); en = 0; tick(5);
    drain("R7 disabled no pulse");
    en = 1; exp_q.push_back(cyc + 12);
    tick(11);
    chk(pls == 1'b0, "R7 not early after re-enable", pls, 0);
    tick(1);
    chk(pls == 1'b1, "R7 full limit after re-enable", pls, 1);
    tick(3);
    drain("R7 pulse");

    // R8: inactive transfer never times out
    act = 0; tick(50);
    drain("R8 idle silent");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule